// File: doc/BRIEF.md
# Output protection fault controller

This block supervises one switched power output. It takes comparator flags for supply under-voltage, supply over-voltage, a low over-current threshold and a high over-current threshold, together with the commanded output-enable bit. From these it decides whether the gate may be driven. It also drives an active-low fault status line and keeps three sticky fault bits that a serial status read clears.

Faults do not all behave alike. Over-voltage holds the output off only while it lasts. Under-voltage holds it off until the command has been seen low. Over-current is latched and re-arms only when the command goes from low to high while no over-current condition is present. The low over-current flag must persist through a programmable filter window before it trips. The high flag trips at once. Under-voltage and over-voltage protection can each be disabled. A disabled condition still sets its status bit, so it serves as a warning. All outputs are registered and respond one clock after the inputs.

Top module: `prot_fault_ctrl`

## Requirements
- R1: With under-voltage protection enabled, an under-voltage flag turns the gate off, drives the fault line low and sets the under-voltage bit, all one cycle later.
- R2: If the command is low once the under-voltage flag has gone, the fault line returns high, and the under-voltage bit stays set until a status read.
- R3: If the command is high when under-voltage ends, the gate stays off and the fault line stays low until the command goes low. The gate turns on after the command returns high.
- R4: With under-voltage protection disabled, the flag has no effect on the gate or the fault line, but the under-voltage bit is still set.
- R5: An over-voltage flag with protection enabled turns the gate off only while it persists. It does not pull the fault line low. Its bit stays set after the flag is gone.
- R6: With over-voltage protection disabled, the gate follows the command during over-voltage, and the over-voltage bit is still set.
- R7: The low over-current flag trips the over-current latch when it has been high for (OC_BASE << sel) + 1 consecutive cycles. Any cycle with the flag low restarts the count. sel=0 gives 4 and sel=1 gives 8 with the defaults.
- R8: The high over-current flag latches the over-current fault at once. The result is gate off, fault line low and over-current bit set, one cycle later, whatever the filter selection.
- R9: A latched over-current fault is cleared only in a cycle where the command is high, the command was low the cycle before, and no over-current trip is present. Holding the command low, or keeping it high, leaves the fault latched.
- R10: A status read clears each sticky bit whose condition is absent in that cycle. A bit whose condition is still present stays set.
- R11: After reset the gate is off, the fault line is high and all sticky bits are 0. Without faults, the gate equals the command one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uv_flag_i | input | 1 | Supply under-voltage comparator flag |
| ov_flag_i | input | 1 | Supply over-voltage comparator flag |
| ocl_flag_i | input | 1 | Low over-current threshold flag |
| och_flag_i | input | 1 | High over-current threshold flag |
| out_cmd_i | input | 1 | Commanded output enable |
| uv_prot_off_i | input | 1 | 1 disables under-voltage protection |
| ov_prot_off_i | input | 1 | 1 disables over-voltage protection |
| oc_time_sel_i | input | OC_SEL_W | Over-current filter selection; window is OC_BASE << sel cycles |
| status_rd_i | input | 1 | One-cycle status read strobe |
| gate_en_o | output | 1 | Gate drive enable |
| fault_n_o | output | 1 | Active-low fault status |
| uv_bit_o | output | 1 | Sticky under-voltage bit |
| ov_bit_o | output | 1 | Sticky over-voltage bit |
| oc_bit_o | output | 1 | Sticky over-current bit |

## Verification
Under-voltage is tried with the command high and with it low at recovery. The first case exercises the hold-until-low path and the second the immediate fault-line release. Both are repeated with protection disabled, which separates status reporting from output control. Over-voltage is run enabled and disabled to show that it is non-latching. The over-current flags are run as a high-threshold pulse with the command held high, held low and rising into an active trip. The low-threshold flag is held exactly at and one past each window, and interrupted by a single low cycle, which tests the counter restart. Reads coincide with conditions that are present and with ones that are absent.

// File: rtl/pf_pkg.sv
package pf_pkg;

    typedef enum int unsigned {
        FLT_UV = 0,
        FLT_OV = 1,
        FLT_OC = 2
    } flt_idx_e;

    localparam int unsigned NUM_FLT = 3;

    typedef struct packed {
        logic uv_hold;
        logic oc_hold;
        logic gate_en;
        logic fault_n;
    } core_state_t;

endpackage

// File: rtl/pf_oc_filter.sv
module pf_oc_filter #(
    parameter int unsigned OC_BASE  = 4,
    parameter int unsigned OC_SEL_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ocl_i,
    input  logic [OC_SEL_W-1:0] sel_i,
    output logic                expired_o
);
    localparam int unsigned MAX_LIM = OC_BASE << ((1 << OC_SEL_W) - 1);
    localparam int unsigned CNT_W   = $clog2(MAX_LIM + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = CNT_W'(OC_BASE) << sel_i;
        cnt_d = cnt_q;
        if (!ocl_i) begin
            cnt_d = '0;
        end else if (cnt_q != CNT_W'(MAX_LIM)) begin
            cnt_d = cnt_q + 1'b1;
        end
        expired_o = ocl_i && (cnt_q >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/pf_rearm_edge.sv
module pf_rearm_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_i,
    output logic rise_o
);
    logic cmd_d, cmd_q;

    always_comb begin
        cmd_d  = cmd_i;
        rise_o = cmd_i && !cmd_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= 1'b0;
        end else begin
            cmd_q <= cmd_d;
        end
    end
endmodule

// File: rtl/pf_sticky_bits.sv
module pf_sticky_bits #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cond_i,
    input  logic         rd_i,
    output logic [N-1:0] bits_o
);
    logic [N-1:0] bits_d, bits_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_comb begin
            bits_d[i] = cond_i[i] || (bits_q[i] && !rd_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            bits_q <= bits_d;
        end
    end

    assign bits_o = bits_q;
endmodule

// File: rtl/prot_fault_ctrl.sv
module prot_fault_ctrl #(
    parameter int unsigned OC_BASE  = 4,
    parameter int unsigned OC_SEL_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                uv_flag_i,
    input  logic                ov_flag_i,
    input  logic                ocl_flag_i,
    input  logic                och_flag_i,
    input  logic                out_cmd_i,
    input  logic                uv_prot_off_i,
    input  logic                ov_prot_off_i,
    input  logic [OC_SEL_W-1:0] oc_time_sel_i,
    input  logic                status_rd_i,
    output logic                gate_en_o,
    output logic                fault_n_o,
    output logic                uv_bit_o,
    output logic                ov_bit_o,
    output logic                oc_bit_o
);
    import pf_pkg::*;

    core_state_t st_d, st_q;
    logic ocl_expired;
    logic cmd_rise;
    logic oc_trip;
    logic uv_act;
    logic ov_act;
    logic [NUM_FLT-1:0] cond;
    logic [NUM_FLT-1:0] sticky;

    pf_oc_filter #(
        .OC_BASE (OC_BASE),
        .OC_SEL_W(OC_SEL_W)
    ) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .ocl_i    (ocl_flag_i),
        .sel_i    (oc_time_sel_i),
        .expired_o(ocl_expired)
    );

    pf_rearm_edge u_rearm (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd_i (out_cmd_i),
        .rise_o(cmd_rise)
    );

    always_comb begin
        uv_act  = uv_flag_i && !uv_prot_off_i;
        ov_act  = ov_flag_i && !ov_prot_off_i;
        oc_trip = och_flag_i || ocl_expired;

        cond         = '0;
        cond[FLT_UV] = uv_flag_i;
        cond[FLT_OV] = ov_flag_i;
        cond[FLT_OC] = oc_trip;

        st_d         = st_q;
        st_d.uv_hold = uv_act || (st_q.uv_hold && out_cmd_i);
        st_d.oc_hold = oc_trip || (st_q.oc_hold && !cmd_rise);
        st_d.gate_en = out_cmd_i && !st_d.uv_hold && !st_d.oc_hold && !ov_act;
        st_d.fault_n = !(st_d.uv_hold || st_d.oc_hold);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{uv_hold: 1'b0, oc_hold: 1'b0, gate_en: 1'b0, fault_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    pf_sticky_bits #(
        .N(NUM_FLT)
    ) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .cond_i(cond),
        .rd_i  (status_rd_i),
        .bits_o(sticky)
    );

    assign gate_en_o = st_q.gate_en;
    assign fault_n_o = st_q.fault_n;
    assign uv_bit_o  = sticky[FLT_UV];
    assign ov_bit_o  = sticky[FLT_OV];
    assign oc_bit_o  = sticky[FLT_OC];
endmodule

// File: rtl/pf_checker.sv
module pf_checker (
    input logic clk,
    input logic rst_n,
    input logic uv_flag_i,
    input logic ov_flag_i,
    input logic och_flag_i,
    input logic out_cmd_i,
    input logic uv_prot_off_i,
    input logic ov_prot_off_i,
    input logic status_rd_i,
    input logic gate_en_o,
    input logic fault_n_o,
    input logic uv_bit_o,
    input logic ov_bit_o,
    input logic oc_bit_o
);
    AST_UV_SHUTS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_flag_i && !uv_prot_off_i) |=> (!gate_en_o && !fault_n_o && uv_bit_o)); // R1

    AST_UV_BIT_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_flag_i && uv_prot_off_i) |=> uv_bit_o); // R4

    AST_OV_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_flag_i && !ov_prot_off_i) |=> (!gate_en_o && ov_bit_o)); // R5

    AST_OCH_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        och_flag_i |=> (!gate_en_o && !fault_n_o && oc_bit_o)); // R8

    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_bit_o && !status_rd_i) |=> uv_bit_o); // R10

    AST_NO_CMD_NO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_cmd_i |=> !gate_en_o); // R11
endmodule

bind prot_fault_ctrl pf_checker u_pf_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .uv_flag_i    (uv_flag_i),
    .ov_flag_i    (ov_flag_i),
    .och_flag_i   (och_flag_i),
    .out_cmd_i    (out_cmd_i),
    .uv_prot_off_i(uv_prot_off_i),
    .ov_prot_off_i(ov_prot_off_i),
    .status_rd_i  (status_rd_i),
    .gate_en_o    (gate_en_o),
    .fault_n_o    (fault_n_o),
    .uv_bit_o     (uv_bit_o),
    .ov_bit_o     (ov_bit_o),
    .oc_bit_o     (oc_bit_o)
);

// File: tb/prot_fault_ctrl_bench.sv
module prot_fault_ctrl_bench;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC       = 22;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       uv = 1'b0, ov = 1'b0, ocl = 1'b0, och = 1'b0, cmd = 1'b0;
    logic       uvd = 1'b0, ovd = 1'b0, rd = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       gate, fn, uvb, ovb, ocb;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    prot_fault_ctrl u_prot_fault_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .uv_flag_i    (uv),
        .ov_flag_i    (ov),
        .ocl_flag_i   (ocl),
        .och_flag_i   (och),
        .out_cmd_i    (cmd),
        .uv_prot_off_i(uvd),
        .ov_prot_off_i(ovd),
        .oc_time_sel_i(sel),
        .status_rd_i  (rd),
        .gate_en_o    (gate),
        .fault_n_o    (fn),
        .uv_bit_o     (uvb),
        .ov_bit_o     (ovb),
        .oc_bit_o     (ocb)
    );

    // inputs {uv, ov, ocl, och, cmd, uv_off, ov_off, rd} ; expected {gate, fault_n, uvb, ovb, ocb}
    localparam logic [12:0] VEC [NVEC] = '{
        {8'b00001000, 5'b11000},  // 1  R11 normal
        {8'b10001000, 5'b00100},  // 2  R1
        {8'b00001000, 5'b00100},  // 3  R3 held while cmd high
        {8'b00000000, 5'b01100},  // 4  R3 cmd low releases fault line
        {8'b00001001, 5'b11000},  // 5  R3 gate back, R10 read clears
        {8'b10000000, 5'b00100},  // 6  R1 with cmd low
        {8'b00000000, 5'b01100},  // 7  R2
        {8'b10001100, 5'b11100},  // 8  R4
        {8'b10001101, 5'b11100},  // 9  R10 present keeps bit
        {8'b00001101, 5'b11000},  // 10 R10 absent clears
        {8'b01001000, 5'b01010},  // 11 R5
        {8'b00001000, 5'b11010},  // 12 R5 non-latching
        {8'b00001001, 5'b11000},  // 13 R5 read clears
        {8'b01001010, 5'b11010},  // 14 R6
        {8'b01001011, 5'b11010},  // 15 R6 R10
        {8'b00011001, 5'b00001},  // 16 R8 R10
        {8'b00001000, 5'b00001},  // 17 R9 held
        {8'b00000000, 5'b00001},  // 18 R9 low alone
        {8'b00001001, 5'b11000},  // 19 R9 rearm
        {8'b00010000, 5'b00001},  // 20 R8 with cmd low
        {8'b00011000, 5'b00001},  // 21 R9 rise with trip present
        {8'b00001000, 5'b00001}   // 22 R9 no new rise
    };

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%0b exp=%0b", req, what, act, exp);
        end
    endtask

    task automatic step(input logic [7:0] in);
        {uv, ov, ocl, och, cmd, uvd, ovd, rd} = in;
        @(posedge clk);
        #1;
    endtask

    task automatic chk_all(input string req, input logic [4:0] exp);
        chk(req, "gate",    gate, exp[4]);
        chk(req, "fault_n", fn,   exp[3]);
        chk(req, "uv_bit",  uvb,  exp[2]);
        chk(req, "ov_bit",  ovb,  exp[1]);
        chk(req, "oc_bit",  ocb,  exp[0]);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog act=running exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk_all("R11 reset", 5'b01000);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][12:5]);
            chk_all($sformatf("vector %0d", i + 1), VEC[i][4:0]);
        end

        // R9 rearm then R7 filter, sel=0 -> trips on 5th high cycle
        step(8'b00000000);
        step(8'b00001001);
        chk("R9", "gate after rearm", gate, 1'b1);
        for (int k = 0; k < 4; k++) step(8'b00101000);
        chk("R7", "gate at window", gate, 1'b1);
        step(8'b00101000);
        chk("R7", "gate past window", gate, 1'b0);
        chk("R7", "oc_bit past window", ocb, 1'b1);

        // R7 interrupted flag restarts count
        step(8'b00000000);
        step(8'b00001001);
        for (int k = 0; k < 4; k++) step(8'b00101000);
        step(8'b00001000);
        for (int k = 0; k < 4; k++) step(8'b00101000);
        chk("R7", "gate after restart", gate, 1'b1);
        chk("R7", "oc_bit after restart", ocb, 1'b0);

        // R7 sel=1 -> trips on 9th high cycle
        sel = 2'd1;
        step(8'b00001000);
        for (int k = 0; k < 8; k++) step(8'b00101000);
        chk("R7", "gate at sel1 window", gate, 1'b1);
        step(8'b00101000);
        chk("R7", "gate past sel1 window", gate, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule